// File: doc/BRIEF.md
# Narrow Bus Transfer Sequencer

This block connects a processor-side request port to an external bus that moves a single byte per bus cycle. A request names an access size (byte, word or double word), a start address, a direction and a space (memory or I/O). The block breaks the request into one, two or four single-byte bus cycles. Bytes are taken in little-endian order starting at the requested address, with no forced alignment.

On the bus side the block drives a 20-bit address, active-low read and write strobes, an I/O select line and an outgoing byte. It samples an incoming byte and a ready input. Read bytes are gathered into a 32-bit result, which is returned together with a one-cycle done pulse.

Memory and I/O share the one address bus. An I/O cycle raises the select line and uses only a 16-bit address. Between two byte cycles of the same request, both strobes return high for one cycle, so every byte shows on the bus as a separate transfer.

Top module: `narrow_bus_seq`

## Requirements
- R1: A request with size code 0 makes exactly 1 bus transfer, code 1 makes 2, and codes 2 and 3 make 4. After each transfer completes, both strobes are high for at least one cycle.
- R2: In memory space, transfer k (k = 0, 1, ...) drives bus_addr = (req_addr + k) mod 2^20 for any start address, odd or unaligned.
- R3: bus_rd_n and bus_wr_n are never low together. Both are high whenever busy is low. A read request drives only bus_rd_n low, and a write request drives only bus_wr_n low.
- R4: During write transfer k, bus_dout carries req_wdata[8k+7:8k].
- R5: After a read, rdata[8k+7:8k] holds the byte sampled on bus_din at transfer k, and unused upper bytes are zero. rdata keeps the last read result through later write requests.
- R6: In I/O space (req_io = 1), bus_io is high during every transfer. bus_addr[19:16] is zero, and bus_addr[15:0] = (req_addr[15:0] + k) mod 2^16.
- R7: A transfer completes only in a cycle where bus_rdy is high. While a strobe is low and bus_rdy is low, the strobes, bus_addr and bus_dout stay unchanged.
- R8: A request is accepted only while busy is low. busy rises in the cycle after acceptance and falls in the cycle in which done is high. A req_valid pulse seen while busy is ignored.
- R9: done is high for exactly one cycle, in the cycle after the last transfer completes. With W wait cycles per byte and N bytes, done appears N*(1+W)+N-1 cycles after the first busy cycle.
- R10: After reset, both strobes are high, and busy, done, bus_io, bus_addr and rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 double word |
| req_addr | input | 20 | Start (lowest) byte address |
| req_wdata | input | 32 | Write data, low byte first on the bus |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read result |
| bus_addr | output | 20 | Byte address of the current transfer |
| bus_io | output | 1 | High during I/O transfers |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | 8 | Outgoing write byte |
| bus_din | input | 8 | Incoming read byte |
| bus_rdy | input | 1 | Transfer completes when high |

## Verification
A wrong byte index would show on the first transfer after it goes wrong: bus_addr or bus_dout would not match the expected byte, or the read result would hold a byte in the wrong lane once done rises. A wrong state or a wrong last-index value would change the number of strobe pulses, or move done off its cycle count, within the same request. Ready is held low for several cycles in one pass, which exposes any transfer that finishes without ready. A pulse on req_valid during a busy request would add extra strobes within a few cycles.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    typedef enum logic [1:0] {
        NBS_IDLE   = 2'd0,
        NBS_ACTIVE = 2'd1,
        NBS_GAP    = 2'd2
    } nbs_state_e;
endpackage

// File: rtl/nbs_addr_gen.sv
module nbs_addr_gen #(
    parameter int ADDR_W = 20,
    parameter int IO_W   = 16,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              io_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] mem_addr;
    logic [IO_W-1:0]   io_addr;

    // memory space wraps at 2^ADDR_W, I/O space at 2^IO_W
    assign mem_addr = base_i + ADDR_W'(idx_i);
    assign io_addr  = base_i[IO_W-1:0] + IO_W'(idx_i);

    generate
        if (ADDR_W > IO_W) begin : g_pad
            assign addr_o = io_i ? {{(ADDR_W-IO_W){1'b0}}, io_addr} : mem_addr;
        end else begin : g_flat
            assign addr_o = io_i ? io_addr : mem_addr;
        end
    endgenerate
endmodule

// File: rtl/nbs_lane_sel.sv
module nbs_lane_sel #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [LANES*LANE_W-1:0] word_i,
    input  logic [IDX_W-1:0]        sel_i,
    output logic [LANE_W-1:0]       lane_o
);
    always_comb begin
        lane_o = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel_i == IDX_W'(k)) begin
                lane_o = word_i[k*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/nbs_lane_merge.sv
module nbs_lane_merge #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [LANES*LANE_W-1:0] acc_i,
    input  logic [LANE_W-1:0]       lane_i,
    input  logic [IDX_W-1:0]        sel_i,
    output logic [LANES*LANE_W-1:0] acc_o
);
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign acc_o[k*LANE_W +: LANE_W] =
                (sel_i == IDX_W'(k)) ? lane_i : acc_i[k*LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/narrow_bus_seq.sv
module narrow_bus_seq
    import nbs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int IO_W      = 16,
    parameter int LANE_W    = 8,
    parameter int MAX_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic                        req_io,
    input  logic [1:0]                  req_size,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [MAX_BYTES*LANE_W-1:0] req_wdata,
    output logic                        busy,
    output logic                        done,
    output logic [MAX_BYTES*LANE_W-1:0] rdata,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic                        bus_io,
    output logic                        bus_rd_n,
    output logic                        bus_wr_n,
    output logic [LANE_W-1:0]           bus_dout,
    input  logic [LANE_W-1:0]           bus_din,
    input  logic                        bus_rdy
);
    localparam int DATA_W = MAX_BYTES * LANE_W;
    localparam int IDX_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    typedef struct packed {
        nbs_state_e        st;
        logic              wr;
        logic              io;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } nbs_regs_t;

    nbs_regs_t         r_q, r_d;
    int unsigned       nb_c;
    logic [ADDR_W-1:0] gen_addr;
    logic [LANE_W-1:0] out_lane;
    logic [DATA_W-1:0] merged;
    logic              strobe_on;

    nbs_addr_gen #(.ADDR_W(ADDR_W), .IO_W(IO_W), .IDX_W(IDX_W)) u_addr (
        .base_i (r_q.base),
        .idx_i  (r_q.idx),
        .io_i   (r_q.io),
        .addr_o (gen_addr)
    );

    nbs_lane_sel #(.LANE_W(LANE_W), .LANES(MAX_BYTES), .IDX_W(IDX_W)) u_sel (
        .word_i (r_q.wdata),
        .sel_i  (r_q.idx),
        .lane_o (out_lane)
    );

    nbs_lane_merge #(.LANE_W(LANE_W), .LANES(MAX_BYTES), .IDX_W(IDX_W)) u_merge (
        .acc_i  (r_q.rdata),
        .lane_i (bus_din),
        .sel_i  (r_q.idx),
        .acc_o  (merged)
    );

    // byte count of the incoming request, clamped to the widest access
    always_comb begin
        nb_c = 32'd1 << req_size;
        if (nb_c > int'(MAX_BYTES)) begin
            nb_c = int'(MAX_BYTES);
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            NBS_IDLE: begin
                if (req_valid) begin
                    r_d.st    = NBS_ACTIVE;
                    r_d.wr    = req_write;
                    r_d.io    = req_io;
                    r_d.base  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.idx   = '0;
                    r_d.last  = IDX_W'(nb_c - 1);
                    if (!req_write) begin
                        r_d.rdata = '0;
                    end
                end
            end
            NBS_ACTIVE: begin
                if (bus_rdy) begin
                    if (!r_q.wr) begin
                        r_d.rdata = merged;
                    end
                    if (r_q.idx == r_q.last) begin
                        r_d.st   = NBS_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st  = NBS_GAP;
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
            end
            NBS_GAP: begin
                r_d.st = NBS_ACTIVE;
            end
            default: begin
                r_d.st = NBS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign strobe_on = (r_q.st == NBS_ACTIVE);
    assign busy      = (r_q.st != NBS_IDLE);
    assign done      = r_q.done;
    assign rdata     = r_q.rdata;
    assign bus_rd_n  = !(strobe_on && !r_q.wr);
    assign bus_wr_n  = !(strobe_on && r_q.wr);
    assign bus_io    = strobe_on && r_q.io;
    assign bus_addr  = strobe_on ? gen_addr : '0;
    assign bus_dout  = (strobe_on && r_q.wr) ? out_lane : '0;
endmodule

// File: rtl/nbs_chk.sv
module nbs_chk #(
    parameter int ADDR_W = 20,
    parameter int IO_W   = 16,
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_io,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [LANE_W-1:0] bus_dout,
    input logic              bus_rdy
);
    logic strobe;
    assign strobe = !bus_rd_n || !bus_wr_n;

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_rd_n && bus_wr_n));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !bus_rdy) |=> ($stable(bus_addr) && $stable(bus_rd_n)
                                  && $stable(bus_wr_n) && $stable(bus_dout)));

    // R1
    gap_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && bus_rdy) |=> (bus_rd_n && bus_wr_n));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> strobe);

    // R6
    io_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && bus_io) |-> ((bus_addr >> IO_W) == '0));
endmodule

bind narrow_bus_seq nbs_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W), .LANE_W(LANE_W)) u_nbs_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .bus_addr (bus_addr),
    .bus_io   (bus_io),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_dout (bus_dout),
    .bus_rdy  (bus_rdy)
);

// File: tb/tb_narrow_bus_seq.sv
module tb_narrow_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done;
    logic [31:0] rdata;
    logic [19:0] bus_addr;
    logic        bus_io, bus_rd_n, bus_wr_n;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_din = '0;
    logic        bus_rdy = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wait_n = 0;
    int wcnt = 0;
    int rec_n = 0;
    logic [19:0] rec_addr [16];
    logic        rec_io   [16];
    logic        rec_wr   [16];
    logic [7:0]  rec_data [16];
    logic [31:0] last_rd = '0;

    narrow_bus_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .bus_addr(bus_addr), .bus_io(bus_io), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_rdy(bus_rdy)
    );

    always #5 clk = ~clk;

    // stimulus: {write, io, size[1:0], addr[19:0], wdata[31:0]}
    localparam int NV = 9;
    localparam logic [55:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd0, 20'h00125, 32'h0},
        {1'b0, 1'b0, 2'd1, 20'h00193, 32'h0},
        {1'b0, 1'b0, 2'd2, 20'h00192, 32'h0},
        {1'b0, 1'b0, 2'd2, 20'hFFFFE, 32'h0},
        {1'b1, 1'b0, 2'd1, 20'h0007D, 32'h0000BEEF},
        {1'b1, 1'b0, 2'd2, 20'h12345, 32'hDEADC0DE},
        {1'b0, 1'b1, 2'd1, 20'hAFFFF, 32'h0},
        {1'b1, 1'b1, 2'd2, 20'h3FFFE, 32'h11223344},
        {1'b0, 1'b0, 2'd3, 20'h00401, 32'h0}
    };

    function automatic logic [7:0] mdl(input logic [19:0] a, input logic io);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ (io ? 8'hA5 : 8'h3C);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // bus responder: drives data and ready away from the active edge
    always @(negedge clk) begin
        if (!bus_rd_n || !bus_wr_n) begin
            bus_din = mdl(bus_addr, bus_io);
            if (wcnt < wait_n) begin
                bus_rdy = 1'b0;
                wcnt++;
            end else begin
                bus_rdy = 1'b1;
                wcnt = 0;
                if (rec_n < 16) begin
                    rec_addr[rec_n] = bus_addr;
                    rec_io[rec_n]   = bus_io;
                    rec_wr[rec_n]   = !bus_wr_n;
                    rec_data[rec_n] = bus_dout;
                end
                rec_n++;
            end
        end else begin
            bus_rdy = 1'b0;
            wcnt = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 60000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic issue(input logic wr, input logic io, input logic [1:0] sz,
                         input logic [19:0] ad, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_io = io;
        req_size = sz; req_addr = ad; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_op(input logic wr, input logic io, input logic [1:0] sz,
                             input logic [19:0] ad, input logic [31:0] wd,
                             input int t0);
        int nb;
        int t;
        logic [19:0] ea;
        logic [31:0] exp_rd;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        t = t0;
        exp_rd = '0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R9 done seen", 32'(done), 32'd1);
        chk(t == nb*(1+wait_n)+nb-1, "R9 done latency", 32'(t), 32'(nb*(1+wait_n)+nb-1));
        chk(busy == 1'b0, "R8 busy low with done", 32'(busy), 32'd0);
        chk(rec_n == nb, "R1 transfer count", 32'(rec_n), 32'(nb));
        for (int k = 0; k < nb && k < rec_n; k++) begin
            if (io) ea = {4'h0, ad[15:0] + 16'(k)};
            else    ea = ad + 20'(k);
            chk(rec_addr[k] == ea, io ? "R6 io address" : "R2 mem address",
                32'(rec_addr[k]), 32'(ea));
            chk(rec_io[k] == io, "R6 io select", 32'(rec_io[k]), 32'(io));
            chk(rec_wr[k] == wr, "R3 strobe direction", 32'(rec_wr[k]), 32'(wr));
            if (wr) chk(rec_data[k] == wd[8*k +: 8], "R4 write byte",
                        32'(rec_data[k]), 32'(wd[8*k +: 8]));
            else    exp_rd[8*k +: 8] = mdl(ea, io);
        end
        if (!wr) begin
            chk(rdata == exp_rd, "R5 read assembly", rdata, exp_rd);
            last_rd = exp_rd;
        end else begin
            chk(rdata == last_rd, "R5 result held over write", rdata, last_rd);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 single-cycle done", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(bus_rd_n && bus_wr_n, "R10 strobes high", {30'd0, bus_rd_n, bus_wr_n}, 32'd3);
        chk(!busy && !done, "R10 busy/done low", {30'd0, busy, done}, 32'd0);
        chk(rdata == '0, "R10 rdata zero", rdata, 32'd0);
        chk(bus_addr == '0 && !bus_io, "R10 bus quiet", 32'(bus_addr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: no wait states, then R7 with two wait cycles per byte
        for (int pass = 0; pass < 2; pass++) begin
            wait_n = (pass == 0) ? 0 : 2;
            for (int i = 0; i < NV; i++) begin
                rec_n = 0;
                issue(VEC[i][55], VEC[i][54], VEC[i][53:52], VEC[i][51:32], VEC[i][31:0]);
                chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
                finish_op(VEC[i][55], VEC[i][54], VEC[i][53:52], VEC[i][51:32],
                          VEC[i][31:0], 0);
            end
        end

        // R8: request pulse during a busy read is ignored
        wait_n = 0;
        rec_n = 0;
        issue(1'b0, 1'b0, 2'd2, 20'h00050, 32'h0);
        req_valid = 1'b1; req_write = 1'b1; req_io = 1'b1;
        req_size = 2'd2; req_addr = 20'h0FF00; req_wdata = 32'hCAFEF00D;
        @(negedge clk);
        req_valid = 1'b0;
        finish_op(1'b0, 1'b0, 2'd2, 20'h00050, 32'h0, 1);
        repeat (6) @(negedge clk);
        chk(rec_n == 4, "R8 ignored request adds no transfer", 32'(rec_n), 32'd4);
        chk(busy == 1'b0, "R8 idle after ignored request", 32'(busy), 32'd0);

        // R7: long ready stall on a single write byte
        wait_n = 7;
        rec_n = 0;
        issue(1'b1, 1'b0, 2'd0, 20'hFFFFF, 32'h000000A7);
        finish_op(1'b1, 1'b0, 2'd0, 20'hFFFFF, 32'h000000A7, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule